// File: doc/BRIEF.md
# Multi-Context Operand Forwarding Matrix

This block sits between a register-free array of ALU stages and the argument registers of a host processor. It decides which value arrives at every ALU source port. Each source port can take a host argument register, a temporary register inside the matrix, or the live result of an ALU in an earlier stage. The routing comes from a context: one packed word of switch settings. Several contexts are stored in slots, and a loader fills them before execution starts.

During a run, a branch outcome elsewhere picks the next context index. The matrix copies that slot into its active settings and holds them until the next load. All dynamic switching therefore happens in the matrix, and the ALU array stays static. Temporary registers capture ALU results on enabled steps. A value captured from a late stage can feed an early stage on the following step, which makes the forwarding bidirectional. On exit, the active context can write temporary values back into the argument registers, where the host reads them.

Top module: `fwd_matrix`

## Requirements
- R1: After reset, every temporary register, argument register and context slot is zero. The active context index is 0, and the active settings are all zero, so every source port shows argument register 0, which is 0.
- R2: A write with cfgWrEn and cfgWrIdx below 6 stores cfgWrData into that slot. It does not change the routing until a load selects that slot, and this holds even when the slot written is the one currently active.
- R3: ctxLoad with ctxIdx below 6 makes activeCtx equal ctxIdx after the clock edge, and the routing follows that slot from then on. Without ctxLoad, the active index and the active settings hold.
- R4: ctxLoad with ctxIdx of 6 or 7 is ignored, and both activeCtx and the routing stay unchanged.
- R5: Context word layout and argument sources. Source port p = (stage*2 + alu)*2 + src (4 stages, 2 ALUs per stage, 2 sources per ALU) takes its 5-bit select from bits [5p+4:5p]. Select codes 0 to 3 pick argument registers 0 to 3.
- R6: Select codes 4 to 11 pick temporary registers 0 to 7.
- R7: Select codes 12 to 19 pick the live result of ALU slot (code-12), where slot = stage*2 + alu. The result is passed only when that slot lies in a stage earlier than the port's own stage. A slot in the same or a later stage yields zero, and so do codes 20 to 31.
- R8: Bit 80+t of the active context enables temporary register t. On a clock edge with stepEn high, an enabled temporary register t loads the result of ALU slot t. A disabled register, or any register when stepEn is low, holds its value.
- R9: A temporary register captured from a late stage can be routed to a port of an earlier stage in the following cycle.
- R10: For argument k, bit 88+4k of the active context enables write-back, and bits [91+4k:89+4k] name a temporary register. On a stepEn edge, an enabled argument loads that temporary register's value as it was before the edge. A host write to the same argument in the same cycle wins.
- R11: hostArgWr stores hostArgData into argument hostArgIdx, visible on argOut after the edge. Argument registers otherwise change only through R10.
- R12: When ctxLoad and stepEn occur in the same cycle, capture and write-back follow the context that was active before the edge. The new context governs from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Context slot write strobe |
| cfgWrIdx | input | 3 | Slot to write |
| cfgWrData | input | 104 | Context word to store |
| ctxLoad | input | 1 | Apply a new context |
| ctxIdx | input | 3 | Context slot to apply |
| stepEn | input | 1 | Execution step: capture temporaries, write back arguments |
| hostArgWr | input | 1 | Host argument write strobe |
| hostArgIdx | input | 2 | Argument register to write |
| hostArgData | input | 32 | Argument value from host |
| stageRes | input | 256 | ALU results, slot s at bits [32s+31:32s] |
| opOut | output | 512 | Operands, port p at bits [32p+31:32p] |
| argOut | output | 128 | Argument registers, k at bits [32k+31:32k] |
| activeCtx | output | 3 | Index of the applied context |

## Verification
Two pairs of functions can meet in one clock edge. The first pair is a context switch and an execution step. The bench raises ctxLoad and stepEn together while the outgoing context enables temporary 7 and the incoming one enables temporary 6. It then reads both temporaries through the new routing and expects only temporary 7 to hold the new ALU result. The second pair is a context write-back and a host write to the same argument register. These are fired together, and the bench expects the host value on argOut while a neighbouring argument receives its write-back value.

// File: rtl/fmx_pkg.sv
package fmx_pkg;

  // Strobes from control to datapath, one bit per action in a cycle.
  typedef struct packed {
    logic cfgWr;    // store a context word into a valid slot
    logic loadCtx;  // copy a valid slot into the active settings
    logic capture;  // execution step: temporaries and write-back
    logic hostWr;   // host writes an argument register
  } fmx_strobe_t;

endpackage

// File: rtl/fmx_ctrl.sv
module fmx_ctrl
  import fmx_pkg::*;
#(
  parameter int NUM_CTX = 6,
  parameter int CTX_IW  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CTX_IW-1:0] cfgWrIdx,
  input  logic              ctxLoad,
  input  logic [CTX_IW-1:0] ctxIdx,
  input  logic              stepEn,
  input  logic              hostArgWr,
  output fmx_strobe_t       strobes,
  output logic [CTX_IW-1:0] activeCtx
);

  localparam logic [CTX_IW:0] CTX_LIMIT = (CTX_IW+1)'(NUM_CTX);

  logic loadOk;
  logic cfgOk;

  // Indices beyond the populated slots are rejected here.
  assign loadOk = ctxLoad && ({1'b0, ctxIdx} < CTX_LIMIT);
  assign cfgOk  = cfgWrEn && ({1'b0, cfgWrIdx} < CTX_LIMIT);

  always_comb begin
    strobes.cfgWr   = cfgOk;
    strobes.loadCtx = loadOk;
    strobes.capture = stepEn;
    strobes.hostWr  = hostArgWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCtx <= '0;
    end else if (loadOk) begin
      activeCtx <= ctxIdx;
    end
  end

endmodule

// File: rtl/fmx_datapath.sv
module fmx_datapath
  import fmx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_CTX    = 6,
  parameter int NUM_STAGES = 4,
  parameter int ALUS       = 2,
  parameter int NUM_ARGS   = 4,
  parameter int CTX_IW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int ARG_IW     = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1,
  parameter int NUM_SLOTS  = NUM_STAGES * ALUS,
  parameter int NUM_PORTS  = NUM_SLOTS * 2,
  parameter int NUM_TMP    = NUM_SLOTS,
  parameter int NUM_SRC    = NUM_ARGS + NUM_TMP + NUM_SLOTS,
  parameter int SEL_W      = $clog2(NUM_SRC),
  parameter int TMP_IW     = (NUM_TMP > 1) ? $clog2(NUM_TMP) : 1,
  parameter int WB_W       = 1 + TMP_IW,
  parameter int PORT_BITS  = NUM_PORTS * SEL_W,
  parameter int CFG_W      = PORT_BITS + NUM_TMP + NUM_ARGS * WB_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  fmx_strobe_t                   strobes,
  input  logic [CTX_IW-1:0]             cfgWrIdx,
  input  logic [CFG_W-1:0]              cfgWrData,
  input  logic [CTX_IW-1:0]             ctxIdx,
  input  logic [ARG_IW-1:0]             hostArgIdx,
  input  logic [DATA_W-1:0]             hostArgData,
  input  logic [NUM_SLOTS*DATA_W-1:0]   stageRes,
  output logic [NUM_PORTS*DATA_W-1:0]   opOut,
  output logic [NUM_ARGS*DATA_W-1:0]    argOut
);

  localparam int TEN_BASE = PORT_BITS;
  localparam int WB_BASE  = PORT_BITS + NUM_TMP;
  localparam int LIVE_BASE = NUM_ARGS + NUM_TMP;

  logic [CFG_W-1:0]  ctxMem [NUM_CTX];
  logic [CFG_W-1:0]  activeCfg;
  logic [DATA_W-1:0] tmpReg [NUM_TMP];
  logic [DATA_W-1:0] argReg [NUM_ARGS];

  // Write-back values, taken from temporaries before the edge.
  logic [NUM_ARGS-1:0] wbEn;
  logic [DATA_W-1:0]   wbVal [NUM_ARGS];

  for (genvar k = 0; k < NUM_ARGS; k++) begin : g_wb
    logic [TMP_IW-1:0] wbSel;
    assign wbEn[k] = activeCfg[WB_BASE + k*WB_W];
    assign wbSel   = activeCfg[WB_BASE + k*WB_W + 1 +: TMP_IW];
    always_comb begin
      wbVal[k] = '0;
      for (int t = 0; t < NUM_TMP; t++) begin
        if (wbSel == TMP_IW'(t)) wbVal[k] = tmpReg[t];
      end
    end
    assign argOut[k*DATA_W +: DATA_W] = argReg[k];
  end

  // Context storage and the active shadow copy.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CTX; c++) ctxMem[c] <= '0;
      activeCfg <= '0;
    end else begin
      if (strobes.cfgWr)   ctxMem[cfgWrIdx] <= cfgWrData;
      if (strobes.loadCtx) activeCfg <= ctxMem[ctxIdx];
    end
  end

  // Temporary registers: capture of enabled ALU slots on a step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TMP; t++) tmpReg[t] <= '0;
    end else if (strobes.capture) begin
      for (int t = 0; t < NUM_TMP; t++) begin
        if (activeCfg[TEN_BASE + t]) tmpReg[t] <= stageRes[t*DATA_W +: DATA_W];
      end
    end
  end

  // Argument registers: write-back on a step, host write has priority.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_ARGS; k++) argReg[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_ARGS; k++) begin
        if (strobes.hostWr && (hostArgIdx == ARG_IW'(k))) begin
          argReg[k] <= hostArgData;
        end else if (strobes.capture && wbEn[k]) begin
          argReg[k] <= wbVal[k];
        end
      end
    end
  end

  // Source-port crossbar; live results only from strictly earlier stages.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int STG = p / (2 * ALUS);
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] opnd;
    assign sel = activeCfg[p*SEL_W +: SEL_W];
    always_comb begin
      opnd = '0;
      for (int i = 0; i < NUM_ARGS; i++) begin
        if (sel == SEL_W'(i)) opnd = argReg[i];
      end
      for (int i = 0; i < NUM_TMP; i++) begin
        if (sel == SEL_W'(NUM_ARGS + i)) opnd = tmpReg[i];
      end
      for (int j = 0; j < STG * ALUS; j++) begin
        if (sel == SEL_W'(LIVE_BASE + j)) opnd = stageRes[j*DATA_W +: DATA_W];
      end
    end
    assign opOut[p*DATA_W +: DATA_W] = opnd;
  end

endmodule

// File: rtl/fwd_matrix.sv
module fwd_matrix
  import fmx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_CTX    = 6,
  parameter int NUM_STAGES = 4,
  parameter int ALUS       = 2,
  parameter int NUM_ARGS   = 4,
  parameter int CTX_IW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  parameter int ARG_IW     = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1,
  parameter int NUM_SLOTS  = NUM_STAGES * ALUS,
  parameter int NUM_PORTS  = NUM_SLOTS * 2,
  parameter int NUM_TMP    = NUM_SLOTS,
  parameter int NUM_SRC    = NUM_ARGS + NUM_TMP + NUM_SLOTS,
  parameter int SEL_W      = $clog2(NUM_SRC),
  parameter int TMP_IW     = (NUM_TMP > 1) ? $clog2(NUM_TMP) : 1,
  parameter int CFG_W      = NUM_PORTS * SEL_W + NUM_TMP + NUM_ARGS * (1 + TMP_IW)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [CTX_IW-1:0]           cfgWrIdx,
  input  logic [CFG_W-1:0]            cfgWrData,
  input  logic                        ctxLoad,
  input  logic [CTX_IW-1:0]           ctxIdx,
  input  logic                        stepEn,
  input  logic                        hostArgWr,
  input  logic [ARG_IW-1:0]           hostArgIdx,
  input  logic [DATA_W-1:0]           hostArgData,
  input  logic [NUM_SLOTS*DATA_W-1:0] stageRes,
  output logic [NUM_PORTS*DATA_W-1:0] opOut,
  output logic [NUM_ARGS*DATA_W-1:0]  argOut,
  output logic [CTX_IW-1:0]           activeCtx
);

  fmx_strobe_t strobes;

  fmx_ctrl #(
    .NUM_CTX (NUM_CTX),
    .CTX_IW  (CTX_IW)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrIdx  (cfgWrIdx),
    .ctxLoad   (ctxLoad),
    .ctxIdx    (ctxIdx),
    .stepEn    (stepEn),
    .hostArgWr (hostArgWr),
    .strobes   (strobes),
    .activeCtx (activeCtx)
  );

  fmx_datapath #(
    .DATA_W     (DATA_W),
    .NUM_CTX    (NUM_CTX),
    .NUM_STAGES (NUM_STAGES),
    .ALUS       (ALUS),
    .NUM_ARGS   (NUM_ARGS),
    .CTX_IW     (CTX_IW),
    .ARG_IW     (ARG_IW),
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_PORTS  (NUM_PORTS),
    .NUM_TMP    (NUM_TMP),
    .NUM_SRC    (NUM_SRC),
    .SEL_W      (SEL_W),
    .TMP_IW     (TMP_IW),
    .WB_W       (1 + TMP_IW),
    .PORT_BITS  (NUM_PORTS * SEL_W),
    .CFG_W      (CFG_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgWrIdx    (cfgWrIdx),
    .cfgWrData   (cfgWrData),
    .ctxIdx      (ctxIdx),
    .hostArgIdx  (hostArgIdx),
    .hostArgData (hostArgData),
    .stageRes    (stageRes),
    .opOut       (opOut),
    .argOut      (argOut)
  );

endmodule

// File: rtl/fmx_checker.sv
module fmx_checker #(
  parameter int DATA_W   = 32,
  parameter int NUM_CTX  = 6,
  parameter int NUM_ARGS = 4,
  parameter int CTX_IW   = 3,
  parameter int ARG_IW   = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       ctxLoad,
  input logic [CTX_IW-1:0]          ctxIdx,
  input logic                       stepEn,
  input logic                       hostArgWr,
  input logic [ARG_IW-1:0]          hostArgIdx,
  input logic [DATA_W-1:0]          hostArgData,
  input logic [NUM_ARGS*DATA_W-1:0] argOut,
  input logic [CTX_IW-1:0]          activeCtx
);

  localparam logic [CTX_IW:0] CTX_LIMIT = (CTX_IW+1)'(NUM_CTX);

  function automatic logic [DATA_W-1:0] pickArg(input logic [NUM_ARGS*DATA_W-1:0] v,
                                                input logic [ARG_IW-1:0] idx);
    return v[idx*DATA_W +: DATA_W];
  endfunction

  // R3: without a load request the active index holds
  a_r3_ctx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctxLoad |=> $stable(activeCtx));

  // R3: a valid load makes the requested index active
  a_r3_ctx_load: assert property (@(posedge clk) disable iff (!rstN)
    (ctxLoad && ({1'b0, ctxIdx} < CTX_LIMIT)) |=> (activeCtx == $past(ctxIdx)));

  // R4: an out-of-range load is ignored
  a_r4_bad_idx: assert property (@(posedge clk) disable iff (!rstN)
    (ctxLoad && ({1'b0, ctxIdx} >= CTX_LIMIT)) |=> $stable(activeCtx));

  // R11: a host write lands in the addressed argument register
  a_r11_host_wr: assert property (@(posedge clk) disable iff (!rstN)
    hostArgWr |=> (pickArg(argOut, $past(hostArgIdx)) == $past(hostArgData)));

  // R11: arguments change only on a host write or a step
  a_r11_args_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!hostArgWr && !stepEn) |=> $stable(argOut));

endmodule

bind fwd_matrix fmx_checker #(
  .DATA_W   (DATA_W),
  .NUM_CTX  (NUM_CTX),
  .NUM_ARGS (NUM_ARGS),
  .CTX_IW   (CTX_IW),
  .ARG_IW   (ARG_IW)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctxLoad     (ctxLoad),
  .ctxIdx      (ctxIdx),
  .stepEn      (stepEn),
  .hostArgWr   (hostArgWr),
  .hostArgIdx  (hostArgIdx),
  .hostArgData (hostArgData),
  .argOut      (argOut),
  .activeCtx   (activeCtx)
);

// File: tb/fwd_matrix_tb_top.sv
module fwd_matrix_tb_top;

  localparam int CFG_W = 104;

  logic clk = 1'b0;
  logic rstN;
  logic cfgWrEn;
  logic [2:0] cfgWrIdx;
  logic [CFG_W-1:0] cfgWrData;
  logic ctxLoad;
  logic [2:0] ctxIdx;
  logic stepEn;
  logic hostArgWr;
  logic [1:0] hostArgIdx;
  logic [31:0] hostArgData;
  logic [255:0] stageRes;
  logic [511:0] opOut;
  logic [127:0] argOut;
  logic [2:0] activeCtx;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fwd_matrix dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .ctxLoad(ctxLoad), .ctxIdx(ctxIdx), .stepEn(stepEn),
    .hostArgWr(hostArgWr), .hostArgIdx(hostArgIdx), .hostArgData(hostArgData),
    .stageRes(stageRes), .opOut(opOut), .argOut(argOut), .activeCtx(activeCtx)
  );

  function automatic logic [CFG_W-1:0] withSel(input logic [CFG_W-1:0] w, input int p, input int code);
    w[p*5 +: 5] = 5'(code);
    return w;
  endfunction

  function automatic logic [CFG_W-1:0] withTmpEn(input logic [CFG_W-1:0] w, input int t);
    w[80 + t] = 1'b1;
    return w;
  endfunction

  function automatic logic [CFG_W-1:0] withWb(input logic [CFG_W-1:0] w, input int k, input int t);
    w[88 + 4*k] = 1'b1;
    w[89 + 4*k +: 3] = 3'(t);
    return w;
  endfunction

  function automatic logic [31:0] port(input int p);
    return opOut[p*32 +: 32];
  endfunction

  function automatic logic [31:0] arg(input int k);
    return argOut[k*32 +: 32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    cfgWrEn = 1'b0; ctxLoad = 1'b0; stepEn = 1'b0; hostArgWr = 1'b0;
  endtask

  task automatic setRes(input logic [31:0] base);
    for (int j = 0; j < 8; j++) stageRes[j*32 +: 32] = base + 32'(j);
  endtask

  task automatic writeCtx(input int slot, input logic [CFG_W-1:0] w);
    cfgWrEn = 1'b1; cfgWrIdx = 3'(slot); cfgWrData = w;
    cycle();
  endtask

  task automatic loadCtx(input int slot);
    ctxLoad = 1'b1; ctxIdx = 3'(slot);
    cycle();
  endtask

  task automatic t_reset();
    check("R1 activeCtx", 32'(activeCtx), 32'd0);
    check("R1 argOut", argOut[31:0] | argOut[127:96], 32'd0);
    check("R1 port3", port(3), 32'd0);
  endtask

  task automatic t_host();
    for (int i = 0; i < 4; i++) begin
      hostArgWr = 1'b1; hostArgIdx = 2'(i); hostArgData = 32'h1111_0000 + 32'(i);
      cycle();
      check("R11 host write", arg(i), 32'h1111_0000 + 32'(i));
    end
  endtask

  task automatic t_cfg();
    logic [CFG_W-1:0] w = '0;
    for (int p = 0; p < 16; p++) w = withSel(w, p, p % 4);
    writeCtx(1, w);
    check("R2 no effect before load", port(5), 32'h1111_0000);
    loadCtx(1);
    check("R3 active index", 32'(activeCtx), 32'd1);
    check("R5 port5 arg1", port(5), 32'h1111_0001);
    check("R5 port6 arg2", port(6), 32'h1111_0002);
  endtask

  task automatic t_bad();
    loadCtx(6);
    check("R4 idx6 index", 32'(activeCtx), 32'd1);
    check("R4 idx6 routing", port(5), 32'h1111_0001);
    loadCtx(7);
    check("R4 idx7 index", 32'(activeCtx), 32'd1);
  endtask

  task automatic t_temps();
    logic [CFG_W-1:0] w = '0;
    w = withTmpEn(w, 0); w = withTmpEn(w, 7);
    w = withSel(w, 0, 11); w = withSel(w, 1, 4); w = withSel(w, 2, 7);
    writeCtx(2, w);
    loadCtx(2);
    check("R1 temp reset", port(0), 32'd0);
    setRes(32'h2000_0000);
    stepEn = 1'b1;
    cycle();
    check("R9 back to stage0", port(0), 32'h2000_0007);
    check("R6 R8 temp0", port(1), 32'h2000_0000);
    check("R8 disabled temp3", port(2), 32'd0);
    setRes(32'h3000_0000);
    cycle();
    check("R8 hold no step", port(0), 32'h2000_0007);
  endtask

  task automatic t_live();
    logic [CFG_W-1:0] w = '0;
    w = withSel(w, 8, 13); w = withSel(w, 9, 17); w = withSel(w, 10, 19);
    w = withSel(w, 11, 25); w = withSel(w, 0, 12);
    writeCtx(3, w);
    loadCtx(3);
    check("R7 earlier stage", port(8), 32'h3000_0001);
    check("R7 same stage", port(9), 32'd0);
    check("R7 later stage", port(10), 32'd0);
    check("R7 code 25", port(11), 32'd0);
    check("R7 stage0 live", port(0), 32'd0);
    setRes(32'h3100_0000);
    #1;
    check("R7 live follows", port(8), 32'h3100_0001);
  endtask

  task automatic t_wb();
    logic [CFG_W-1:0] w = '0;
    w = withWb(w, 1, 7); w = withWb(w, 2, 0); w = withTmpEn(w, 7);
    w = withSel(w, 0, 11);
    writeCtx(4, w);
    loadCtx(4);
    setRes(32'h4000_0000);
    stepEn = 1'b1;
    hostArgWr = 1'b1; hostArgIdx = 2'd2; hostArgData = 32'hDEAD_0002;
    cycle();
    check("R10 write-back old temp7", arg(1), 32'h2000_0007);
    check("R10 host wins", arg(2), 32'hDEAD_0002);
    check("R10 arg3 untouched", arg(3), 32'h1111_0003);
    check("R8 temp7 new", port(0), 32'h4000_0007);
  endtask

  task automatic t_overlap();
    logic [CFG_W-1:0] w = '0;
    w = withTmpEn(w, 6); w = withSel(w, 0, 10); w = withSel(w, 1, 11);
    writeCtx(5, w);
    setRes(32'h5000_0000);
    ctxLoad = 1'b1; ctxIdx = 3'd5; stepEn = 1'b1;
    cycle();
    check("R12 index", 32'(activeCtx), 32'd5);
    check("R12 old enable used", port(1), 32'h5000_0007);
    check("R12 new enable not used", port(0), 32'd0);
    check("R12 R10 old wb arg1", arg(1), 32'h4000_0007);
    check("R12 R10 old wb arg2", arg(2), 32'h2000_0000);
  endtask

  task automatic t_slot();
    logic [CFG_W-1:0] w = '0;
    w = withSel(w, 0, 3);
    writeCtx(5, w);
    check("R2 active slot write held", port(0), 32'd0);
    loadCtx(5);
    check("R2 R3 reload applies", port(0), 32'h1111_0003);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgWrIdx = '0; cfgWrData = '0;
    ctxLoad = 1'b0; ctxIdx = '0; stepEn = 1'b0; hostArgWr = 1'b0;
    hostArgIdx = '0; hostArgData = '0; stageRes = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_host();
    t_cfg();
    t_bad();
    t_temps();
    t_live();
    t_wb();
    t_overlap();
    t_slot();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule